// File: doc/BRIEF.md
# Bidirectional Common Scan Shifter

This block is the row-scan register of a large matrix display column driver used as a common (row) driver. A 160-column register advances one place on every falling edge of a scan pulse. It runs either as one long chain or as two independent half-length chains. A single select picks which way data travels. The two end pins swap roles with that select: the end that feeds the chain is the serial input, and the far end presents the serial output, so parts can be cascaded. In two-chain mode the second chain is fed from a dedicated auxiliary data input.

Each register bit is turned into a 2-bit drive-level code from the bit, the frame-inversion input and the active-low blanking input. The analog driver stage decodes these codes. The tri-state end pads are modelled as separate in, out and output-enable signals. An undriven input end is taken to read 0, which models a pull-down. The scan pulse is sampled by the block clock, and its falling edge is detected synchronously.

Top module: `com_scan_shifter`

## Requirements
- R1: The register changes only at the first clock edge where `scan_pulse` is sampled low after having been sampled high. It does not change while the pulse stays high, stays low, or rises.
- R2: With `dir_up`=1 and `dual_chain`=0, at a shift column 1 (bit 0) takes `pin_lo_in` and every other column k takes the old value of column k-1.
- R3: With `dir_up`=0 and `dual_chain`=0, at a shift column 160 (bit 159) takes `pin_hi_in` and every other column k takes the old value of column k+1.
- R4: With `dual_chain`=1 the register is two chains: columns 1–80 and columns 81–160. In ascending mode column 81 takes `aux_in`. In descending mode column 80 takes `aux_in`. No bit crosses between columns 80 and 81.
- R5: With `dual_chain`=0, `aux_in` has no effect, and data moves across the 80/81 boundary.
- R6: While `blank_n`=0 the register is cleared at every clock edge, and a coincident scan-pulse falling edge is ignored. After release, the next falling edge shifts normally.
- R7: While `blank_n`=0, every level code is 2'b11 (V5) at once, whatever the bits and frame.
- R8: Level codes are 2'b00=V0, 2'b01=V12, 2'b10=V43 and 2'b11=V5. With `blank_n`=1, the code is chosen from `frame_inv` and the bit:
  - frame 0, bit 0 gives V43
  - frame 0, bit 1 gives V0
  - frame 1, bit 0 gives V12
  - frame 1, bit 1 gives V5
  
  Column k uses `row_level[2k-1:2k-2]`.
- R9: With `dir_up`=0, `pin_lo_oe`=1 and `pin_hi_oe`=0. With `dir_up`=1 the two enables swap. The out signal of the pin that is not enabled is 0.
- R10: The serial output on the enabled pin is the tail of the chain fed by the input pin:
  - single chain, ascending: column 160
  - single chain, descending: column 1
  - dual chain, ascending: column 80
  - dual chain, descending: column 81
- R11: `rst_n` low clears the register and the pulse-edge detector at once, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_pulse | input | 1 | Scan pulse; its falling edge shifts the register |
| dir_up | input | 1 | 1: data moves from column 1 toward column 160; 0: the reverse |
| dual_chain | input | 1 | 1: two 80-column chains; 0: one 160-column chain |
| blank_n | input | 1 | Active-low blanking: clears the register, forces V5 |
| frame_inv | input | 1 | Frame inversion select |
| pin_lo_in | input | 1 | Column-1 end pin, input side |
| pin_lo_out | output | 1 | Column-1 end pin, output side |
| pin_lo_oe | output | 1 | Column-1 end pin output enable |
| pin_hi_in | input | 1 | Column-160 end pin, input side |
| pin_hi_out | output | 1 | Column-160 end pin, output side |
| pin_hi_oe | output | 1 | Column-160 end pin output enable |
| aux_in | input | 1 | Serial input of the second chain in dual mode |
| row_level | output | 320 | Two-bit level code per column |

## Verification
A scan-pulse falling edge and the start of blanking can land on the same clock edge. In that case the clear must win and the shifted bit must be lost. The bench provokes this by lowering the pulse and `blank_n` at the same negative clock edge, with a 1 on the feeding pin. It then judges the result: every code must read V5 while blanked, and after release every code must show an all-zero register, with no trace of the 1. A second collision is an asynchronous reset raised mid-cycle while the register holds data. The bench checks the cleared state before the next clock edge.

// File: rtl/com_scan_pkg.sv
package com_scan_pkg;
   typedef enum logic [1:0] {
      LVL_V0  = 2'b00,
      LVL_V12 = 2'b01,
      LVL_V43 = 2'b10,
      LVL_V5  = 2'b11
   } drive_lvl_t;

   localparam int unsigned LVL_W = 2;

   function automatic drive_lvl_t pick_level(input logic frame, input logic on_n, input logic bit_v);
      drive_lvl_t l;
      if (!on_n)
         l = LVL_V5;
      else begin
         unique case ({frame, bit_v})
            2'b00:   l = LVL_V43;
            2'b01:   l = LVL_V0;
            2'b10:   l = LVL_V12;
            default: l = LVL_V5;
         endcase
      end
      return l;
   endfunction
endpackage

// File: rtl/pulse_fall_detect.sv
module pulse_fall_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse_i,
   output logic fall_o
);
   logic pulse_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= pulse_i;
   end

   assign fall_o = pulse_q & ~pulse_i;
endmodule

// File: rtl/scan_chain.sv
module scan_chain #(
   parameter int unsigned COLS = 160
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            shift_i,
   input  logic            clear_i,
   input  logic            up_i,
   input  logic            split_i,
   input  logic            feed_lo_i,
   input  logic            feed_hi_i,
   input  logic            aux_i,
   output logic [COLS-1:0] state_o,
   output logic            tail_o
);
   localparam int unsigned HALF = COLS / 2;

   logic [COLS-1:0] q;
   logic [COLS-1:0] nxt;

   for (genvar c = 0; c < COLS; c++) begin : g_col
      logic from_lo;
      logic from_hi;
      if (c == 0) begin : g_lo_end
         assign from_lo = feed_lo_i;
      end else if (c == HALF) begin : g_lo_mid
         assign from_lo = split_i ? aux_i : q[c-1];
      end else begin : g_lo_mid_n
         assign from_lo = q[c-1];
      end
      if (c == COLS - 1) begin : g_hi_end
         assign from_hi = feed_hi_i;
      end else if (c == HALF - 1) begin : g_hi_mid
         assign from_hi = split_i ? aux_i : q[c+1];
      end else begin : g_hi_mid_n
         assign from_hi = q[c+1];
      end
      assign nxt[c] = up_i ? from_lo : from_hi;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (clear_i) q <= '0;
      else if (shift_i) q <= nxt;
   end

   always_comb begin
      if (up_i) tail_o = split_i ? q[HALF-1] : q[COLS-1];
      else      tail_o = split_i ? q[HALF]   : q[0];
   end

   assign state_o = q;
endmodule

// File: rtl/level_map.sv
module level_map #(
   parameter int unsigned COLS = 160
) (
   input  logic [COLS-1:0]                       bits_i,
   input  logic                                  frame_i,
   input  logic                                  on_n_i,
   output logic [COLS*com_scan_pkg::LVL_W-1:0]   level_o
);
   import com_scan_pkg::*;

   for (genvar c = 0; c < COLS; c++) begin : g_lvl
      assign level_o[c*LVL_W +: LVL_W] = pick_level(frame_i, on_n_i, bits_i[c]);
   end
endmodule

// File: rtl/com_scan_shifter.sv
module com_scan_shifter #(
   parameter int unsigned COLS = 160
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scan_pulse,
   input  logic                  dir_up,
   input  logic                  dual_chain,
   input  logic                  blank_n,
   input  logic                  frame_inv,
   input  logic                  pin_lo_in,
   output logic                  pin_lo_out,
   output logic                  pin_lo_oe,
   input  logic                  pin_hi_in,
   output logic                  pin_hi_out,
   output logic                  pin_hi_oe,
   input  logic                  aux_in,
   output logic [2*COLS-1:0]     row_level
);
   localparam int unsigned HALF = COLS / 2;

   if (COLS < 4 || (COLS % 2) != 0) begin : g_bad_cols
      $error("com_scan_shifter: COLS must be even and at least 4");
   end

   logic            lp_fall;
   logic [COLS-1:0] col_q;
   logic            tail;
   logic            feed_lo;
   logic            feed_hi;

   pulse_fall_detect u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .pulse_i (scan_pulse),
      .fall_o  (lp_fall)
   );

   assign feed_lo = dir_up  & pin_lo_in;
   assign feed_hi = ~dir_up & pin_hi_in;

   scan_chain #(.COLS(COLS)) u_chain (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_i   (lp_fall),
      .clear_i   (~blank_n),
      .up_i      (dir_up),
      .split_i   (dual_chain),
      .feed_lo_i (feed_lo),
      .feed_hi_i (feed_hi),
      .aux_i     (aux_in),
      .state_o   (col_q),
      .tail_o    (tail)
   );

   level_map #(.COLS(COLS)) u_map (
      .bits_i  (col_q),
      .frame_i (frame_inv),
      .on_n_i  (blank_n),
      .level_o (row_level)
   );

   assign pin_lo_oe  = ~dir_up;
   assign pin_hi_oe  = dir_up;
   assign pin_lo_out = ~dir_up & tail;
   assign pin_hi_out = dir_up & tail;
endmodule

// File: rtl/com_scan_shifter_chk.sv
module com_scan_shifter_chk #(
   parameter int unsigned COLS = 160
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fall,
   input logic              blank_n,
   input logic              dir_up,
   input logic              dual_chain,
   input logic              frame_inv,
   input logic              pin_lo_in,
   input logic              pin_hi_in,
   input logic              aux_in,
   input logic [COLS-1:0]   col_q,
   input logic [2*COLS-1:0] row_level,
   input logic              pin_lo_out,
   input logic              pin_lo_oe,
   input logic              pin_hi_out,
   input logic              pin_hi_oe
);
   localparam int unsigned HALF = COLS / 2;

   assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!fall && blank_n) |=> $stable(col_q));

   assert_up_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && blank_n && dir_up) |=> (col_q[0] == $past(pin_lo_in)) && (col_q[1] == $past(col_q[0])));

   assert_down_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && blank_n && !dir_up) |=> (col_q[COLS-1] == $past(pin_hi_in)) && (col_q[0] == $past(col_q[1])));

   assert_aux_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && blank_n && dual_chain && dir_up) |=> col_q[HALF] == $past(aux_in));

   assert_aux_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && blank_n && dual_chain && !dir_up) |=> col_q[HALF-1] == $past(aux_in));

   assert_single_cross_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && blank_n && !dual_chain && dir_up) |=> col_q[HALF] == $past(col_q[HALF-1]));

   assert_blank_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !blank_n |=> col_q == '0);

   assert_blank_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !blank_n |-> row_level == '1);

   assert_lvl_f0_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_n && !frame_inv) |-> row_level[1:0] == (col_q[0] ? 2'b00 : 2'b10));

   assert_lvl_f1_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_n && frame_inv) |-> row_level[1:0] == (col_q[0] ? 2'b11 : 2'b01));

   assert_oe_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot({pin_lo_oe, pin_hi_oe}) && (pin_hi_oe == dir_up));

   assert_idle_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!pin_lo_oe |-> !pin_lo_out) and (!pin_hi_oe |-> !pin_hi_out));

   assert_tail_up_R10: assert property (@(posedge clk) disable iff (!rst_n)
      dir_up |-> pin_hi_out == (dual_chain ? col_q[HALF-1] : col_q[COLS-1]));

   assert_tail_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_up |-> pin_lo_out == (dual_chain ? col_q[HALF] : col_q[0]));

   always @(negedge clk) begin
      if (!rst_n) begin
         assert_reset_clear_R11: assert (col_q == '0);
      end
   end
endmodule

bind com_scan_shifter com_scan_shifter_chk #(.COLS(COLS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fall       (lp_fall),
   .blank_n    (blank_n),
   .dir_up     (dir_up),
   .dual_chain (dual_chain),
   .frame_inv  (frame_inv),
   .pin_lo_in  (feed_lo),
   .pin_hi_in  (feed_hi),
   .aux_in     (aux_in),
   .col_q      (col_q),
   .row_level  (row_level),
   .pin_lo_out (pin_lo_out),
   .pin_lo_oe  (pin_lo_oe),
   .pin_hi_out (pin_hi_out),
   .pin_hi_oe  (pin_hi_oe)
);

// File: tb/com_scan_shifter_test.sv
module com_scan_shifter_test;
   localparam int N = 160;
   localparam int H = N / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b1;
   logic scan_pulse = 1'b0;
   logic dir_up = 1'b0;
   logic dual_chain = 1'b0;
   logic blank_n = 1'b1;
   logic frame_inv = 1'b0;
   logic pin_lo_in = 1'b0;
   logic pin_hi_in = 1'b0;
   logic aux_in = 1'b0;
   logic pin_lo_out, pin_lo_oe, pin_hi_out, pin_hi_oe;
   logic [2*N-1:0] row_level;

   always #5 clk = ~clk;

   com_scan_shifter uut (
      .clk(clk), .rst_n(rst_n), .scan_pulse(scan_pulse), .dir_up(dir_up),
      .dual_chain(dual_chain), .blank_n(blank_n), .frame_inv(frame_inv),
      .pin_lo_in(pin_lo_in), .pin_lo_out(pin_lo_out), .pin_lo_oe(pin_lo_oe),
      .pin_hi_in(pin_hi_in), .pin_hi_out(pin_hi_out), .pin_hi_oe(pin_hi_oe),
      .aux_in(aux_in), .row_level(row_level)
   );

   typedef struct {
      logic [2*N-1:0] lv;
      logic [3:0]     pins;
      string          tag;
   } exp_t;

   exp_t q[$];
   event smp;
   int checks = 0;
   int fails = 0;
   bit done = 0;
   logic [N-1:0] m = '0;

   function automatic logic [2*N-1:0] exp_levels();
      logic [2*N-1:0] v;
      for (int c = 0; c < N; c++) begin
         if (!blank_n) v[2*c +: 2] = 2'b11;
         else case ({frame_inv, m[c]})
            2'b00: v[2*c +: 2] = 2'b10;
            2'b01: v[2*c +: 2] = 2'b00;
            2'b10: v[2*c +: 2] = 2'b01;
            default: v[2*c +: 2] = 2'b11;
         endcase
      end
      return v;
   endfunction

   function automatic logic [3:0] exp_pins();
      logic s;
      if (dir_up) s = dual_chain ? m[H-1] : m[N-1];
      else        s = dual_chain ? m[H]   : m[0];
      return dir_up ? {1'b0, 1'b0, s, 1'b1} : {s, 1'b1, 1'b0, 1'b0};
   endfunction

   function automatic logic [N-1:0] model_shift(input logic e1, input logic e2, input logic ax);
      logic [N-1:0] n;
      for (int i = 0; i < N; i++) begin
         if (dir_up) begin
            if (i == 0) n[i] = e1;
            else if (dual_chain && i == H) n[i] = ax;
            else n[i] = m[i-1];
         end else begin
            if (i == N-1) n[i] = e2;
            else if (dual_chain && i == H-1) n[i] = ax;
            else n[i] = m[i+1];
         end
      end
      return n;
   endfunction

   task automatic push(input string tag);
      exp_t e;
      e.lv = exp_levels();
      e.pins = exp_pins();
      e.tag = tag;
      q.push_back(e);
      -> smp;
   endtask

   initial begin
      forever begin
         @(smp);
         #2;
         while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (row_level !== e.lv) begin
               fails++;
               $display("FAIL %s levels act=%h exp=%h", e.tag, row_level, e.lv);
            end
            checks++;
            if ({pin_lo_out, pin_lo_oe, pin_hi_out, pin_hi_oe} !== e.pins) begin
               fails++;
               $display("FAIL %s pins act=%b exp=%b", e.tag,
                        {pin_lo_out, pin_lo_oe, pin_hi_out, pin_hi_oe}, e.pins);
            end
         end
      end
   end

   task automatic pulse(input logic e1, input logic e2, input logic ax, input string tag);
      @(negedge clk) scan_pulse = 1'b1;
      @(negedge clk);
      scan_pulse = 1'b0;
      pin_lo_in = e1; pin_hi_in = e2; aux_in = ax;
      @(negedge clk);
      if (blank_n) m = model_shift(e1, e2, ax);
      else m = '0;
      push(tag);
   endtask

   task automatic pulse_blank(input logic e1, input logic e2, input string tag);
      @(negedge clk) scan_pulse = 1'b1;
      @(negedge clk);
      scan_pulse = 1'b0;
      blank_n = 1'b0;
      pin_lo_in = e1; pin_hi_in = e2;
      @(negedge clk);
      m = '0;
      push(tag);
   endtask

   task automatic set_blank(input logic v, input string tag);
      @(negedge clk) blank_n = v;
      @(negedge clk);
      if (!v) m = '0;
      push(tag);
   endtask

   task automatic set_mode(input logic d, input logic s, input logic f, input string tag);
      @(negedge clk);
      dir_up = d; dual_chain = s; frame_inv = f;
      pin_lo_in = 1'b0; pin_hi_in = 1'b0;
      push(tag);
   endtask

   task automatic hold(input string tag);
      @(negedge clk) scan_pulse = 1'b1;
      pin_lo_in = ~pin_lo_in; pin_hi_in = ~pin_hi_in; aux_in = ~aux_in;
      repeat (4) @(negedge clk);
      pin_lo_in = ~pin_lo_in; pin_hi_in = ~pin_hi_in;
      push(tag);
   endtask

   task automatic async_reset(input string tag);
      @(negedge clk);
      #1 rst_n = 1'b0;
      m = '0;
      push(tag);
      @(negedge clk) rst_n = 1'b1;
      push(tag);
   endtask

   initial begin
      #1 rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      push("R11 reset state");

      // R3 R5: single descending, aux toggled must not matter
      for (int i = 0; i < 12; i++) pulse(1'b0, (i % 3) == 0, i[0], "R3 R5");
      hold("R1 no shift without falling edge");
      // R10: push bits out through column 1
      for (int i = 0; i < 160; i++) pulse(1'b0, (i % 5) < 2, 1'b1, "R10 R3");
      set_mode(1'b0, 1'b0, 1'b1, "R8 frame 1");
      for (int i = 0; i < 4; i++) pulse(1'b0, i[0], 1'b0, "R8");
      // R2 R9: single ascending
      set_mode(1'b1, 1'b0, 1'b0, "R9 direction swap");
      for (int i = 0; i < 20; i++) pulse((i % 4) != 1, 1'b0, ~i[0], "R2 R5");
      // R4 R10: dual ascending
      set_mode(1'b1, 1'b1, 1'b0, "R4 R10 dual up");
      for (int i = 0; i < 30; i++) pulse(i[1], 1'b0, (i % 3) == 2, "R4 R10");
      // R4 R10: dual descending
      set_mode(1'b0, 1'b1, 1'b1, "R4 R9 dual down");
      for (int i = 0; i < 30; i++) pulse(1'b0, (i % 3) == 0, i[2], "R4 R10");
      // R6 R7: blanking
      set_blank(1'b0, "R7 forced V5");
      pulse(1'b0, 1'b1, 1'b1, "R6 shift ignored while blanked");
      set_blank(1'b1, "R6 register cleared");
      pulse(1'b0, 1'b1, 1'b0, "R6 resume after release");
      set_mode(1'b0, 1'b0, 1'b0, "R8 frame 0");
      for (int i = 0; i < 3; i++) pulse(1'b0, 1'b1, 1'b0, "R3");
      // coincident blank and falling edge
      pulse_blank(1'b0, 1'b1, "R6 coincident clear wins");
      set_blank(1'b1, "R6 R7 no trace of shifted bit");
      for (int i = 0; i < 6; i++) pulse(1'b0, 1'b1, 1'b0, "R3");
      async_reset("R11 async clear");
      pulse(1'b0, 1'b1, 1'b0, "R11 R3 after reset");
      repeat (3) @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule